// File: doc/BRIEF.md
# Clock Generator Configuration Slave (SMBus Block Write)

This block is the configuration front end of a multi-output clock generator. It watches the two SMBus lines, SCL and SDA, through a synchronizer in the system clock domain. It recognises start and stop conditions and shifts in bytes MSB first. It pulls SDA low in the acknowledge slot of every byte it accepts. The only transaction it accepts is a block write. The transaction starts with the slave address and the write direction, followed by a fixed command code and a byte count. The data bytes that follow fill the configuration registers in rising order, starting at register 0.

The seven byte-wide registers drive the generator's controls as one flat parallel bus. These controls include spread-spectrum enable, the 48/66 MHz select of a shared output, per-output enables and CPU free-run bits. Some bits are read-only. They carry the live CPU-stop pin, the live current-multiplier pin, the mode straps captured during reset, and a fixed vendor/revision code. Each data byte is committed as soon as it has been received, so the master may stop after any complete byte.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: While reset is high and on the first cycle after it, `sda_drive_low` is 0 and the registers read: byte0 = {3'b000, halt pin, 1'b0, straps}, byte1 = {mult pin, 7'h07}, byte2 = 8'h7F, byte3 = 8'hC7, byte4 = 8'h3F, byte5 = 8'h00, byte6 = 8'h08. Byte k occupies `cfg_o[8k+7:8k]`.
- R2: An address byte of 8'hD2 (7-bit address 7'h69 with write bit 0) is acknowledged by driving SDA low for the ninth clock. Any other address byte, including 8'hD3, is not acknowledged, and no further byte is acknowledged or written until the next start condition.
- R3: After an accepted address, a command byte of 8'h00 is acknowledged. Any other value is not acknowledged, and the rest of the transaction is ignored.
- R4: A byte count of 1 to 32 is acknowledged. A count of 0 or above 32 is not acknowledged, and the rest of the transaction is ignored.
- R5: Data bytes are acknowledged and written MSB first into register 0, 1, 2 and onward in order, one register per byte. A register changes only while SCL is low.
- R6: A stop after any complete data byte keeps every byte already received. Registers beyond the last byte keep their earlier values.
- R7: Data bytes beyond register 6, up to the declared count, are acknowledged and discarded. Once the count is used up, further bytes are not acknowledged.
- R8: Writes to read-only bits have no effect. The read-only bits are byte0 bits 6, 4, 2:0; byte1 bit 7; byte2 bit 7; byte4 bits 7:6; byte5 bits 7:6; and all of byte6. Byte0 bit 4 follows `halt_pin_i` and byte1 bit 7 follows `mult_pin_i` at all times.
- R9: Byte0 bits 2:0 hold the value `strap_i` had during reset and ignore later changes of `strap_i`.
- R10: A repeated start inside a transaction restarts address matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SMBus clock line as seen on the bus |
| sda_i | input | 1 | SMBus data line as seen on the bus |
| sda_drive_low | output | 1 | 1 pulls SDA low (acknowledge) |
| halt_pin_i | input | 1 | Live CPU-stop pin level, reflected in byte0 bit 4 |
| mult_pin_i | input | 1 | Live current-multiplier pin, reflected in byte1 bit 7 |
| strap_i | input | 3 | Mode straps, captured while reset is high |
| cfg_o | output | 56 | Register bank, byte k at bits 8k+7:8k |

## Verification
The bus write of register 0 and a change of the live CPU-stop status bit can land in the same clock cycle, because both feed byte 0. The bench provokes this by toggling `halt_pin_i` on the cycle in which the last bit of data byte 0 is taken in and committed. It then expects the writable bits to carry the written value, bit 4 to carry the new pin level, and the strap bits to keep their reset-time value. Acknowledge bits are judged through a scoreboard of expected ack/no-ack per byte, including the nacked bytes that follow a rejected address, command or count.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_COUNT,
        PH_DATA,
        PH_IGNORE
    } phase_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    // reset value of the writable bits of each register
    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            1:       return 8'h07;
            2:       return 8'h7F;
            3:       return 8'hC7;
            4:       return 8'h3F;
            default: return 8'h00;
        endcase
    endfunction

    // bits the bus may change
    function automatic logic [7:0] reg_wmask(input int idx);
        case (idx)
            0:       return 8'hA8;
            1:       return 8'h7F;
            2:       return 8'h7F;
            3:       return 8'hFF;
            4:       return 8'h3F;
            5:       return 8'h3F;
            default: return 8'h00;
        endcase
    endfunction

    // value shown on the read-only bits
    function automatic logic [7:0] ro_value(input int idx, input logic halt,
                                            input logic mult, input logic [2:0] strap);
        case (idx)
            0:       return {3'b000, halt, 1'b0, strap};
            1:       return {mult, 7'b0};
            6:       return 8'h08;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import cfgslv_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_now;
    logic              sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_now;
            sda_d    <= sda_now;
        end
    end

    assign scl_now     = scl_pipe[STAGES-1];
    assign sda_now     = sda_pipe[STAGES-1];
    assign ev.sda      = sda_now;
    assign ev.scl_rise = scl_now & ~scl_d;
    assign ev.scl_fall = ~scl_now & scl_d;
    assign ev.start    = scl_now & scl_d & sda_d & ~sda_now;
    assign ev.stop     = scl_now & scl_d & ~sda_d & sda_now;

endmodule

// File: rtl/smb_byte_ctrl.sv
module smb_byte_ctrl
    import cfgslv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h69,
    parameter logic [7:0] CMD_CODE  = 8'h00,
    parameter int         MAX_COUNT = 32,
    parameter int         NUM_REGS  = 7
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    output logic    sda_drive_low,
    output wr_req_t wr
);
    localparam int CNT_W = $clog2(MAX_COUNT + 1);

    phase_e             phase, phase_nx;
    logic [BYTE_W-1:0]  shreg;
    logic [3:0]         bitcnt;
    logic               in_ack;
    logic [CNT_W-1:0]   remain, remain_nx;
    logic [IDX_W-1:0]   ptr, ptr_nx;
    logic               ack_now;
    wr_req_t            wr_nx;

    // decision taken when a whole byte has been shifted in
    always_comb begin
        ack_now   = 1'b0;
        phase_nx  = PH_IGNORE;
        remain_nx = remain;
        ptr_nx    = ptr;
        wr_nx     = '0;
        case (phase)
            PH_ADDR: begin
                if (shreg == {DEV_ADDR, 1'b0}) begin
                    ack_now  = 1'b1;
                    phase_nx = PH_CMD;
                end
            end
            PH_CMD: begin
                if (shreg == CMD_CODE) begin
                    ack_now  = 1'b1;
                    phase_nx = PH_COUNT;
                end
            end
            PH_COUNT: begin
                if (shreg != '0 && int'(shreg) <= MAX_COUNT) begin
                    ack_now   = 1'b1;
                    phase_nx  = PH_DATA;
                    remain_nx = CNT_W'(shreg);
                    ptr_nx    = '0;
                end
            end
            PH_DATA: begin
                if (remain != '0) begin
                    ack_now   = 1'b1;
                    phase_nx  = PH_DATA;
                    remain_nx = remain - 1'b1;
                    if (int'(ptr) < NUM_REGS) begin
                        wr_nx.valid = 1'b1;
                        wr_nx.idx   = ptr;
                        wr_nx.data  = shreg;
                        ptr_nx      = ptr + 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase         <= PH_IDLE;
            shreg         <= '0;
            bitcnt        <= '0;
            in_ack        <= 1'b0;
            remain        <= '0;
            ptr           <= '0;
            sda_drive_low <= 1'b0;
            wr            <= '0;
        end else begin
            wr <= '0;
            if (ev.start) begin
                phase         <= PH_ADDR;
                bitcnt        <= '0;
                in_ack        <= 1'b0;
                sda_drive_low <= 1'b0;
            end else if (ev.stop) begin
                phase         <= PH_IDLE;
                bitcnt        <= '0;
                in_ack        <= 1'b0;
                sda_drive_low <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (ev.scl_rise && !in_ack && bitcnt < 4'd8) begin
                    shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                    bitcnt <= bitcnt + 1'b1;
                end
                if (ev.scl_fall) begin
                    if (in_ack) begin
                        in_ack        <= 1'b0;
                        sda_drive_low <= 1'b0;
                        bitcnt        <= '0;
                    end else if (bitcnt == 4'd8) begin
                        in_ack        <= 1'b1;
                        sda_drive_low <= ack_now;
                        phase         <= phase_nx;
                        remain        <= remain_nx;
                        ptr           <= ptr_nx;
                        wr            <= wr_nx;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfgslv_pkg::*;
#(
    parameter int NUM_REGS = 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  wr_req_t                  wr,
    input  logic                     halt_pin_i,
    input  logic                     mult_pin_i,
    input  logic [2:0]               strap_i,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);
    logic [2:0] strap_q;

    // straps are taken only while reset holds
    always_ff @(posedge clk) begin
        if (rst) strap_q <= strap_i;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] WMASK = reg_wmask(g);
        localparam logic [7:0] RSTV  = reg_default(g);
        logic [7:0] store;
        logic [2:0] strap_view;

        assign strap_view = rst ? strap_i : strap_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                store <= RSTV;
            end else if (wr.valid && wr.idx == IDX_W'(g)) begin
                store <= wr.data & WMASK;
            end
        end

        assign cfg_o[g*BYTE_W +: BYTE_W] =
            (store & WMASK) | (ro_value(g, halt_pin_i, mult_pin_i, strap_view) & ~WMASK);
    end

endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave
    import cfgslv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter logic [7:0] CMD_CODE    = 8'h00,
    parameter int         MAX_COUNT   = 32,
    parameter int         NUM_REGS    = 7,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_drive_low,
    input  logic                  halt_pin_i,
    input  logic                  mult_pin_i,
    input  logic [2:0]            strap_i,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    bus_ev_t ev;
    wr_req_t wr;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    smb_byte_ctrl #(
        .DEV_ADDR  (DEV_ADDR),
        .CMD_CODE  (CMD_CODE),
        .MAX_COUNT (MAX_COUNT),
        .NUM_REGS  (NUM_REGS)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .ev            (ev),
        .sda_drive_low (sda_drive_low),
        .wr            (wr)
    );

    cfg_regbank #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr),
        .halt_pin_i (halt_pin_i),
        .mult_pin_i (mult_pin_i),
        .strap_i    (strap_i),
        .cfg_o      (cfg_o)
    );

endmodule

// File: rtl/cfgslv_chk.sv
module cfgslv_chk #(
    parameter int NUM_REGS = 7
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  scl_i,
    input logic                  sda_drive_low,
    input logic [NUM_REGS*8-1:0] cfg_o
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!sda_drive_low && cfg_o[23:16] == 8'h7F && cfg_o[55:48] == 8'h08)); // R1

    AST_ACK_SET_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> !scl_i); // R2

    AST_ACK_DROP_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_drive_low) |-> !scl_i); // R2

    AST_WRITE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable({cfg_o[47:16], cfg_o[14:8]}) |-> !scl_i); // R5

    AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(cfg_o[2:0])); // R9

endmodule

bind clkgen_cfg_slave cfgslv_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .scl_i         (scl_i),
    .sda_drive_low (sda_drive_low),
    .cfg_o         (cfg_o)
);

// File: tb/sim_clkgen_cfg_slave.sv
module sim_clkgen_cfg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        halt = 1'b0;
    logic        mult = 1'b1;
    logic [2:0]  strap = 3'b101;
    logic        sda_drive_low;
    logic [55:0] cfg;
    logic        sda_bus;
    logic        ack_seen;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic  ack;
        string tag;
    } exp_t;
    exp_t exp_q[$];
    event ack_ev;

    assign sda_bus = sda_m & ~sda_drive_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkgen_cfg_slave u0 (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (scl_m),
        .sda_i         (sda_bus),
        .sda_drive_low (sda_drive_low),
        .halt_pin_i    (halt),
        .mult_pin_i    (mult),
        .strap_i       (strap),
        .cfg_o         (cfg)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_reg(input string tag, input int idx, input logic [7:0] exp);
        check(tag, cfg[idx*8 +: 8], exp);
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
        repeat (4) @(negedge clk);
    endtask

    // driver: shifts a byte out and queues the expected acknowledge
    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q();
            scl_m = 1'b1; wait_q(); wait_q();
            scl_m = 1'b0; wait_q();
        end
        sda_m = 1'b1;
        exp_q.push_back('{ack: exp_ack, tag: tag});
        wait_q();
        scl_m = 1'b1; wait_q();
        ack_seen = ~sda_bus;
        -> ack_ev;
        wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic open_write(input logic [7:0] count, input logic count_ack);
        bus_start();
        send_byte(8'hD2, 1'b1, "R2 address D2h");
        send_byte(8'h00, 1'b1, "R3 command 00h");
        send_byte(count, count_ack, "R4 byte count");
    endtask

    // monitor: compares each observed acknowledge with the queue
    initial begin
        forever begin
            @(ack_ev);
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R2 unexpected ack slot actual %b expected none", ack_seen);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " ack"}, {7'b0, ack_seen}, {7'b0, e.ack});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 sda release", {7'b0, sda_drive_low}, 8'h00);
        check_reg("R1 byte0", 0, 8'h05);
        check_reg("R1 byte1", 1, 8'h87);
        check_reg("R1 byte2", 2, 8'h7F);
        check_reg("R1 byte3", 3, 8'hC7);
        check_reg("R1 byte4", 4, 8'h3F);
        check_reg("R1 byte5", 5, 8'h00);
        check_reg("R1 byte6", 6, 8'h08);
        strap = 3'b010;

        // R5 full write, halt pin moves while byte0 is committed
        open_write(8'd7, 1'b1);
        fork
            send_byte(8'hFF, 1'b1, "R5 data0");
            begin repeat (8*4*Q - Q + 3) @(negedge clk); halt = 1'b1; end
        join
        send_byte(8'h00, 1'b1, "R5 data1");
        send_byte(8'h00, 1'b1, "R5 data2");
        send_byte(8'h00, 1'b1, "R5 data3");
        send_byte(8'h00, 1'b1, "R5 data4");
        send_byte(8'hFF, 1'b1, "R5 data5");
        send_byte(8'h00, 1'b1, "R5 data6");
        bus_stop();
        check_reg("R5 byte0 with live halt", 0, 8'hBD);
        check_reg("R5 byte1", 1, 8'h80);
        check_reg("R5 byte2", 2, 8'h00);
        check_reg("R5 byte3", 3, 8'h00);
        check_reg("R5 byte4", 4, 8'h00);
        check_reg("R8 byte5 ro bits", 5, 8'h3F);
        check_reg("R8 byte6 ro", 6, 8'h08);

        // R6 stop after two of five bytes
        open_write(8'd5, 1'b1);
        send_byte(8'h00, 1'b1, "R6 data0");
        send_byte(8'h55, 1'b1, "R6 data1");
        bus_stop();
        check_reg("R6 byte0 kept", 0, 8'h15);
        check_reg("R6 byte1 kept", 1, 8'hD5);
        check_reg("R6 byte2 untouched", 2, 8'h00);
        check_reg("R6 byte5 untouched", 5, 8'h3F);

        // R2 wrong addresses
        bus_start();
        send_byte(8'hD4, 1'b0, "R2 address D4h");
        send_byte(8'h00, 1'b0, "R2 ignored cmd");
        send_byte(8'h02, 1'b0, "R2 ignored count");
        send_byte(8'hFF, 1'b0, "R2 ignored data");
        bus_stop();
        bus_start();
        send_byte(8'hD3, 1'b0, "R2 read direction");
        send_byte(8'hFF, 1'b0, "R2 ignored after D3h");
        bus_stop();
        check_reg("R2 byte0 unchanged", 0, 8'h15);

        // R3 wrong command
        bus_start();
        send_byte(8'hD2, 1'b1, "R3 address");
        send_byte(8'h01, 1'b0, "R3 command 01h");
        send_byte(8'h01, 1'b0, "R3 ignored count");
        send_byte(8'hFF, 1'b0, "R3 ignored data");
        bus_stop();
        check_reg("R3 byte0 unchanged", 0, 8'h15);

        // R4 illegal counts
        open_write(8'd0, 1'b0);
        send_byte(8'hFF, 1'b0, "R4 ignored after count 0");
        bus_stop();
        open_write(8'd33, 1'b0);
        send_byte(8'hFF, 1'b0, "R4 ignored after count 33");
        bus_stop();
        check_reg("R4 byte0 unchanged", 0, 8'h15);

        // R7 maximum count, tail discarded
        open_write(8'd32, 1'b1);
        send_byte(8'hA8, 1'b1, "R7 data0");
        send_byte(8'h7F, 1'b1, "R7 data1");
        send_byte(8'h7F, 1'b1, "R7 data2");
        send_byte(8'hFF, 1'b1, "R7 data3");
        send_byte(8'hFF, 1'b1, "R7 data4");
        send_byte(8'h00, 1'b1, "R7 data5");
        send_byte(8'hFF, 1'b1, "R7 data6");
        for (int k = 7; k < 32; k++) send_byte(8'hAA, 1'b1, "R7 surplus data");
        send_byte(8'hAA, 1'b0, "R7 beyond count");
        bus_stop();
        check_reg("R7 byte0", 0, 8'hBD);
        check_reg("R7 byte1", 1, 8'hFF);
        check_reg("R7 byte2 ro bit7", 2, 8'h7F);
        check_reg("R7 byte3", 3, 8'hFF);
        check_reg("R8 byte4 ro bits", 4, 8'h3F);
        check_reg("R7 byte5", 5, 8'h00);
        check_reg("R8 byte6 after write", 6, 8'h08);

        // R10 repeated start
        open_write(8'd2, 1'b1);
        send_byte(8'h00, 1'b1, "R10 first data");
        bus_start();
        send_byte(8'hD2, 1'b1, "R10 address after restart");
        send_byte(8'h00, 1'b1, "R10 command");
        send_byte(8'h01, 1'b1, "R10 count");
        send_byte(8'h80, 1'b1, "R10 data");
        send_byte(8'h80, 1'b0, "R7 count exhausted");
        bus_stop();
        check_reg("R10 byte0", 0, 8'h95);
        check_reg("R10 byte1 untouched", 1, 8'hFF);

        // R8 live pins, R9 straps
        mult = 1'b0;
        halt = 1'b0;
        strap = 3'b111;
        repeat (3) @(negedge clk);
        check_reg("R8 byte1 follows mult", 1, 8'h7F);
        check_reg("R8 byte0 follows halt", 0, 8'h85);
        check("R9 straps held", {5'b0, cfg[2:0]}, 8'h05);

        repeat (10) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R2 pending acks actual %0d expected 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule